// File: doc/BRIEF.md
# Exception Entry and Vector Generator

This block sits beside the processor's control registers and performs the register side of taking an exception. When a one-cycle request arrives together with an exception kind, the current program counter and a flag saying whether that instruction sits in a branch-delay slot, the block works out where the handler lives. It also computes what the saved-PC registers, the cause code and the status bits must become. Everything it produces is registered and appears on the clock edge that closes the request cycle.

Three families of entry are handled. General exceptions include interrupts, translation faults, bus errors, traps and cache errors. They save the return address in the exception PC unless an exception is already being serviced, and they vector relative to either a fixed boot base or a software-chosen base. The error family (non-maskable interrupt and soft reset) saves into the error PC and jumps to the boot address. Debug entries save into the debug PC and switch on debug mode. The status word itself lives outside the block: its bits are inputs, and the block returns their next values every cycle, with the bits an entry modifies applied in the request cycle.

Top module: `exc_entry_unit`

## Requirements
- R1: While rst is high and on the first edge after it, pc_o is 0xBFC00000, bev_o and erl_o are 1, and exl_o, dm_o, nmi_o, sr_o, ksu_o, bd_o, code_o, epc_o, errpc_o and depc_o are 0.
- R2: A general entry writes code_o with the 5-bit cause code of its kind. The kind input equals the code: 0 interrupt, 1 TLB modify, 2 TLB load, 3 TLB store, 4 and 5 address error load/store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 15 floating point, 30 cache error.
- R3: The handler base of a general entry is 0xBFC00200 when bev_i is 1. Otherwise it is ebase_i with its low 10 bits cleared. The default offset added to that base is 0x180.
- R4: An interrupt (kind 0) with iv_i set uses offset 0x200. Any other kind ignores iv_i.
- R5: A TLB load or store (kind 2 or 3) with refill_i set and exl_i clear uses offset 0x000. With exl_i set, or with refill_i clear, it uses 0x180.
- R6: A cache error (kind 30) uses offset 0x100 when bev_i is 1 and 0x20000100 when bev_i is 0.
- R7: A general entry with exl_i clear loads epc_o with pc_i, or with pc_i−4 when ds_i is 1. It sets bd_o equal to ds_i and drives exl_o to 1.
- R8: A general entry with exl_i set leaves epc_o and bd_o unchanged but still updates pc_o and code_o.
- R9: Kind 24 (non-maskable interrupt) and kind 25 (soft reset) load errpc_o with pc_i, or with pc_i−4 in a delay slot. They drive erl_o and bev_o to 1 and pc_o to 0xBFC00000. Kind 24 also sets nmi_o and kind 25 also sets sr_o.
- R10: Kinds 26 to 29 (debug step, debug interrupt, debug breakpoint, debug data break) load depc_o with pc_i, or with pc_i−4 in a delay slot. They set dm_o and pc_o to 0xBFC00480. An interrupt (kind 0) while dm_i is 1 is taken as a debug entry and leaves code_o untouched.
- R11: Every accepted entry drives ksu_o to 0. A request with any kind not listed in R2, R9 or R10 changes none of pc_o, code_o, bd_o, epc_o, errpc_o or depc_o.
- R12: Without a request, pc_o, code_o, bd_o, epc_o, errpc_o and depc_o hold their values. The status outputs exl_o, erl_o, bev_o, nmi_o, sr_o, ksu_o and dm_o take the values of their inputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle exception request |
| kind_i | input | 5 | Exception kind |
| pc_i | input | 32 | PC of the faulting instruction |
| ds_i | input | 1 | Faulting instruction is in a branch-delay slot |
| refill_i | input | 1 | Translation fault was a missing entry |
| ebase_i | input | 32 | Software exception base |
| exl_i | input | 1 | Current exception-level bit |
| erl_i | input | 1 | Current error-level bit |
| bev_i | input | 1 | Current boot-vector bit |
| iv_i | input | 1 | Dedicated interrupt vector enable |
| dm_i | input | 1 | Currently in debug mode |
| nmi_i | input | 1 | Current NMI status bit |
| sr_i | input | 1 | Current soft-reset status bit |
| ksu_i | input | 2 | Current privilege mode bits |
| pc_o | output | 32 | Next fetch address |
| epc_o | output | 32 | Exception PC |
| errpc_o | output | 32 | Error PC |
| depc_o | output | 32 | Debug PC |
| code_o | output | 5 | Cause code |
| bd_o | output | 1 | Branch-delay cause bit |
| exl_o | output | 1 | Next exception-level bit |
| erl_o | output | 1 | Next error-level bit |
| bev_o | output | 1 | Next boot-vector bit |
| nmi_o | output | 1 | Next NMI status bit |
| sr_o | output | 1 | Next soft-reset status bit |
| ksu_o | output | 2 | Next privilege mode bits |
| dm_o | output | 1 | Next debug-mode flag |

## Verification
Every result of an entry lands one clock after the cycle in which req_i is high. This covers the new PC, the saved PC of the matching family, the cause code and delay bit, and the modified status bits. The pass-through status outputs also trail their inputs by exactly one edge. The bench drives request and operands on a falling edge, drops the request on the following falling edge and reads all outputs at that moment, which is half a period after the one edge that loads them. The hold checks change pc_i, kind_i and the mode inputs with the request low, and read the outputs one falling edge later.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam logic [31:0] VEC_BOOT    = 32'hBFC0_0000;
    localparam logic [31:0] VEC_BEV_GEN = 32'hBFC0_0200;
    localparam logic [31:0] VEC_DEBUG   = 32'hBFC0_0480;

    localparam logic [31:0] OFF_DEFAULT   = 32'h0000_0180;
    localparam logic [31:0] OFF_INTVEC    = 32'h0000_0200;
    localparam logic [31:0] OFF_TLBREFILL = 32'h0000_0000;
    localparam logic [31:0] OFF_CERR_BOOT = 32'h0000_0100;
    localparam logic [31:0] OFF_CERR_RUN  = 32'h2000_0100;

    localparam int CODE_W = 5;

    typedef enum logic [4:0] {
        K_INT    = 5'd0,
        K_TLBMOD = 5'd1,
        K_TLBLD  = 5'd2,
        K_TLBST  = 5'd3,
        K_ADEL   = 5'd4,
        K_ADES   = 5'd5,
        K_IBUS   = 5'd6,
        K_DBUS   = 5'd7,
        K_SYS    = 5'd8,
        K_BRK    = 5'd9,
        K_RSVD   = 5'd10,
        K_CPU    = 5'd11,
        K_OVF    = 5'd12,
        K_TRAP   = 5'd13,
        K_FPE    = 5'd15,
        K_NMI    = 5'd24,
        K_SRST   = 5'd25,
        K_DSTEP  = 5'd26,
        K_DINT   = 5'd27,
        K_DBRK   = 5'd28,
        K_DDATA  = 5'd29,
        K_CACHE  = 5'd30
    } exc_kind_e;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_GENERAL,
        CLS_ERROR,
        CLS_DEBUG
    } exc_class_e;

    typedef enum logic [1:0] {
        SEL_DEFAULT,
        SEL_INTVEC,
        SEL_REFILL,
        SEL_CACHE
    } vec_sel_e;

    typedef struct packed {
        exc_class_e        cls;
        logic [CODE_W-1:0] code;
        vec_sel_e          sel;
        logic              is_nmi;
        logic              is_srst;
    } exc_decode_t;

    function automatic logic [31:0] resume_pc(input logic [31:0] pc, input logic in_slot);
        return in_slot ? (pc - 32'd4) : pc;
    endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_entry_pkg::*;
(
    input  logic [4:0]  kind_i,
    input  logic        dm_i,
    input  logic        iv_i,
    input  logic        refill_i,
    input  logic        exl_i,
    output exc_decode_t dec_o
);

    always_comb begin
        dec_o         = '0;
        dec_o.cls     = CLS_NONE;
        dec_o.sel     = SEL_DEFAULT;
        dec_o.code    = kind_i;
        case (exc_kind_e'(kind_i))
            K_INT: begin
                if (dm_i) begin
                    dec_o.cls = CLS_DEBUG;
                end else begin
                    dec_o.cls = CLS_GENERAL;
                    dec_o.sel = iv_i ? SEL_INTVEC : SEL_DEFAULT;
                end
            end
            K_TLBLD, K_TLBST: begin
                dec_o.cls = CLS_GENERAL;
                dec_o.sel = (refill_i && !exl_i) ? SEL_REFILL : SEL_DEFAULT;
            end
            K_TLBMOD, K_ADEL, K_ADES, K_IBUS, K_DBUS, K_SYS, K_BRK,
            K_RSVD, K_CPU, K_OVF, K_TRAP, K_FPE: begin
                dec_o.cls = CLS_GENERAL;
            end
            K_CACHE: begin
                dec_o.cls = CLS_GENERAL;
                dec_o.sel = SEL_CACHE;
            end
            K_NMI: begin
                dec_o.cls    = CLS_ERROR;
                dec_o.is_nmi = 1'b1;
            end
            K_SRST: begin
                dec_o.cls     = CLS_ERROR;
                dec_o.is_srst = 1'b1;
            end
            K_DSTEP, K_DINT, K_DBRK, K_DDATA: begin
                dec_o.cls = CLS_DEBUG;
            end
            default: begin
                dec_o.cls = CLS_NONE;
            end
        endcase
    end

endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_entry_pkg::*;
#(
    parameter int VEC_ALIGN = 10
) (
    input  exc_decode_t dec_i,
    input  logic        bev_i,
    input  logic [31:0] ebase_i,
    output logic [31:0] target_o
);

    localparam logic [31:0] ALIGN_MASK = (32'd1 << VEC_ALIGN) - 32'd1;

    logic [31:0] base;
    logic [31:0] offset;

    always_comb begin
        base = bev_i ? VEC_BEV_GEN : (ebase_i & ~ALIGN_MASK);
    end

    always_comb begin
        case (dec_i.sel)
            SEL_INTVEC: offset = OFF_INTVEC;
            SEL_REFILL: offset = OFF_TLBREFILL;
            SEL_CACHE:  offset = bev_i ? OFF_CERR_BOOT : OFF_CERR_RUN;
            default:    offset = OFF_DEFAULT;
        endcase
    end

    always_comb begin
        case (dec_i.cls)
            CLS_GENERAL: target_o = base + offset;
            CLS_ERROR:   target_o = VEC_BOOT;
            CLS_DEBUG:   target_o = VEC_DEBUG;
            default:     target_o = VEC_BOOT;
        endcase
    end

endmodule

// File: rtl/exc_state.sv
module exc_state
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  exc_decode_t       dec_i,
    input  logic [31:0]       target_i,
    input  logic [31:0]       pc_i,
    input  logic              ds_i,
    input  logic              exl_i,
    input  logic              erl_i,
    input  logic              bev_i,
    input  logic              dm_i,
    input  logic              nmi_i,
    input  logic              sr_i,
    input  logic [1:0]        ksu_i,
    output logic [31:0]       pc_o,
    output logic [31:0]       epc_o,
    output logic [31:0]       errpc_o,
    output logic [31:0]       depc_o,
    output logic [CODE_W-1:0] code_o,
    output logic              bd_o,
    output logic              exl_o,
    output logic              erl_o,
    output logic              bev_o,
    output logic              nmi_o,
    output logic              sr_o,
    output logic [1:0]        ksu_o,
    output logic              dm_o
);

    logic        take;
    logic [31:0] back_pc;

    assign take    = req_i && (dec_i.cls != CLS_NONE);
    assign back_pc = resume_pc(pc_i, ds_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_o    <= VEC_BOOT;
            epc_o   <= '0;
            errpc_o <= '0;
            depc_o  <= '0;
            code_o  <= '0;
            bd_o    <= 1'b0;
            exl_o   <= 1'b0;
            erl_o   <= 1'b1;
            bev_o   <= 1'b1;
            nmi_o   <= 1'b0;
            sr_o    <= 1'b0;
            ksu_o   <= 2'b00;
            dm_o    <= 1'b0;
        end else begin
            exl_o <= exl_i;
            erl_o <= erl_i;
            bev_o <= bev_i;
            nmi_o <= nmi_i;
            sr_o  <= sr_i;
            ksu_o <= ksu_i;
            dm_o  <= dm_i;
            if (take) begin
                pc_o  <= target_i;
                ksu_o <= 2'b00;
                case (dec_i.cls)
                    CLS_GENERAL: begin
                        code_o <= dec_i.code;
                        if (!exl_i) begin
                            epc_o <= back_pc;
                            bd_o  <= ds_i;
                            exl_o <= 1'b1;
                        end
                    end
                    CLS_ERROR: begin
                        errpc_o <= back_pc;
                        erl_o   <= 1'b1;
                        bev_o   <= 1'b1;
                        if (dec_i.is_nmi)  nmi_o <= 1'b1;
                        if (dec_i.is_srst) sr_o  <= 1'b1;
                    end
                    CLS_DEBUG: begin
                        depc_o <= back_pc;
                        dm_o   <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int VEC_ALIGN = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  logic [4:0]  kind_i,
    input  logic [31:0] pc_i,
    input  logic        ds_i,
    input  logic        refill_i,
    input  logic [31:0] ebase_i,
    input  logic        exl_i,
    input  logic        erl_i,
    input  logic        bev_i,
    input  logic        iv_i,
    input  logic        dm_i,
    input  logic        nmi_i,
    input  logic        sr_i,
    input  logic [1:0]  ksu_i,
    output logic [31:0] pc_o,
    output logic [31:0] epc_o,
    output logic [31:0] errpc_o,
    output logic [31:0] depc_o,
    output logic [4:0]  code_o,
    output logic        bd_o,
    output logic        exl_o,
    output logic        erl_o,
    output logic        bev_o,
    output logic        nmi_o,
    output logic        sr_o,
    output logic [1:0]  ksu_o,
    output logic        dm_o
);

    exc_decode_t dec;
    logic [31:0] target;

    exc_classify u_classify (
        .kind_i   (kind_i),
        .dm_i     (dm_i),
        .iv_i     (iv_i),
        .refill_i (refill_i),
        .exl_i    (exl_i),
        .dec_o    (dec)
    );

    exc_vector #(.VEC_ALIGN(VEC_ALIGN)) u_vector (
        .dec_i    (dec),
        .bev_i    (bev_i),
        .ebase_i  (ebase_i),
        .target_o (target)
    );

    exc_state u_state (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .dec_i    (dec),
        .target_i (target),
        .pc_i     (pc_i),
        .ds_i     (ds_i),
        .exl_i    (exl_i),
        .erl_i    (erl_i),
        .bev_i    (bev_i),
        .dm_i     (dm_i),
        .nmi_i    (nmi_i),
        .sr_i     (sr_i),
        .ksu_i    (ksu_i),
        .pc_o     (pc_o),
        .epc_o    (epc_o),
        .errpc_o  (errpc_o),
        .depc_o   (depc_o),
        .code_o   (code_o),
        .bd_o     (bd_o),
        .exl_o    (exl_o),
        .erl_o    (erl_o),
        .bev_o    (bev_o),
        .nmi_o    (nmi_o),
        .sr_o     (sr_o),
        .ksu_o    (ksu_o),
        .dm_o     (dm_o)
    );

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_i,
    input logic [4:0]  kind_i,
    input logic [31:0] pc_i,
    input logic        ds_i,
    input logic        exl_i,
    input logic        dm_i,
    input logic [31:0] pc_o,
    input logic [31:0] epc_o,
    input logic [4:0]  code_o,
    input logic        bd_o,
    input logic        exl_o,
    input logic        erl_o,
    input logic        bev_o,
    input logic [1:0]  ksu_o,
    input logic        dm_o
);

    logic is_gen, is_err, is_dbg;

    always_comb begin
        is_err = (kind_i == 5'd24) || (kind_i == 5'd25);
        is_dbg = ((kind_i >= 5'd26) && (kind_i <= 5'd29)) || ((kind_i == 5'd0) && dm_i);
        is_gen = (((kind_i <= 5'd13) || (kind_i == 5'd15) || (kind_i == 5'd30))
                  && !((kind_i == 5'd0) && dm_i));
    end

    assert_kernel_R11: assert property (@(posedge clk) disable iff (rst)
        (req_i && (is_gen || is_err || is_dbg)) |=> (ksu_o == 2'b00));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> ($stable(pc_o) && $stable(epc_o) && $stable(code_o) && $stable(bd_o)));

    assert_epc_save_R7: assert property (@(posedge clk) disable iff (rst)
        (req_i && is_gen && !exl_i) |=>
        ((epc_o == ($past(ds_i) ? ($past(pc_i) - 32'd4) : $past(pc_i)))
         && (bd_o == $past(ds_i)) && exl_o));

    assert_epc_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (req_i && is_gen && exl_i) |=> ($stable(epc_o) && $stable(bd_o)));

    assert_error_vec_R9: assert property (@(posedge clk) disable iff (rst)
        (req_i && is_err) |=> ((pc_o == 32'hBFC0_0000) && erl_o && bev_o));

    assert_debug_vec_R10: assert property (@(posedge clk) disable iff (rst)
        (req_i && is_dbg) |=> ((pc_o == 32'hBFC0_0480) && dm_o && $stable(code_o)));

endmodule

bind exc_entry_unit exc_entry_checker u_chk (.*);

// File: tb/exc_entry_unit_test.sv
`timescale 1ns/1ps
module exc_entry_unit_test;

    typedef struct packed {
        logic [4:0]  kind;
        logic [31:0] pc;
        logic        ds;
        logic        refill;
        logic        exl;
        logic        bev;
        logic        iv;
        logic [31:0] exp_pc;
        logic [4:0]  exp_code;
    } vec_t;

    localparam logic [31:0] EB = 32'h8000_1234;
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{5'd8,  32'h0040_0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_1180, 5'd8 },
        '{5'd0,  32'h0040_0200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h8000_1200, 5'd0 },
        '{5'd0,  32'h0040_0300, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'hBFC0_0380, 5'd0 },
        '{5'd2,  32'h0040_0400, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8000_1000, 5'd2 },
        '{5'd3,  32'h0040_0500, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h8000_1180, 5'd3 },
        '{5'd3,  32'h0040_0600, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'hBFC0_0200, 5'd3 },
        '{5'd30, 32'h0040_0700, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'hBFC0_0300, 5'd30},
        '{5'd30, 32'h0040_0800, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA000_1100, 5'd30},
        '{5'd12, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_1180, 5'd12},
        '{5'd15, 32'h0040_0900, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'hBFC0_0380, 5'd15},
        '{5'd1,  32'h0040_0A00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h8000_1180, 5'd1 },
        '{5'd2,  32'h0040_0B00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_1180, 5'd2 }
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_i;
    logic [4:0]  kind_i;
    logic [31:0] pc_i;
    logic        ds_i, refill_i;
    logic [31:0] ebase_i;
    logic        exl_i, erl_i, bev_i, iv_i, dm_i, nmi_i, sr_i;
    logic [1:0]  ksu_i;
    logic [31:0] pc_o, epc_o, errpc_o, depc_o;
    logic [4:0]  code_o;
    logic        bd_o, exl_o, erl_o, bev_o, nmi_o, sr_o, dm_o;
    logic [1:0]  ksu_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_epc;
    logic        m_bd;
    logic [31:0] snap_pc, snap_errpc, snap_depc;
    logic [4:0]  snap_code;

    exc_entry_unit uut (.*);

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_i = 1'b0; kind_i = 5'd0; pc_i = '0; ds_i = 1'b0; refill_i = 1'b0;
        ebase_i = EB; exl_i = 1'b0; erl_i = 1'b0; bev_i = 1'b0; iv_i = 1'b0;
        dm_i = 1'b0; nmi_i = 1'b0; sr_i = 1'b0; ksu_i = 2'b10;
    endtask

    task automatic pulse();
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        bev_i = 1'b1; erl_i = 1'b1; ksu_i = 2'b00;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pc", pc_o, 32'hBFC0_0000);
        check("R1 bev", {31'd0, bev_o}, 32'd1);
        check("R1 erl", {31'd0, erl_o}, 32'd1);
        check("R1 exl/dm/nmi/sr/bd", {27'd0, exl_o, dm_o, nmi_o, sr_o, bd_o}, 32'd0);
        check("R1 code/ksu", {25'd0, code_o, ksu_o}, 32'd0);
        check("R1 saved pcs", epc_o | errpc_o | depc_o, 32'd0);
        rst = 1'b0;
        idle_inputs();
        m_epc = '0;
        m_bd  = 1'b0;
        @(negedge clk);

        // R2..R8: table of general entries
        for (int i = 0; i < NV; i++) begin
            kind_i = VECS[i].kind; pc_i = VECS[i].pc; ds_i = VECS[i].ds;
            refill_i = VECS[i].refill; exl_i = VECS[i].exl; bev_i = VECS[i].bev;
            iv_i = VECS[i].iv;
            if (!VECS[i].exl) begin
                m_epc = VECS[i].ds ? VECS[i].pc - 32'd4 : VECS[i].pc;
                m_bd  = VECS[i].ds;
            end
            pulse();
            check($sformatf("R3/R4/R5/R6 vector %0d pc", i), pc_o, VECS[i].exp_pc);
            check($sformatf("R2 vector %0d code", i), {27'd0, code_o}, {27'd0, VECS[i].exp_code});
            check($sformatf("R7/R8 vector %0d epc", i), epc_o, m_epc);
            check($sformatf("R7/R8 vector %0d bd", i), {31'd0, bd_o}, {31'd0, m_bd});
            check($sformatf("R7 vector %0d exl", i), {31'd0, exl_o}, 32'd1);
            check($sformatf("R11 vector %0d ksu", i), {30'd0, ksu_o}, 32'd0);
        end

        // R12: no request -> registers hold, status follows inputs
        idle_inputs();
        snap_pc = pc_o; snap_code = code_o;
        kind_i = 5'd8; pc_i = 32'h1234_5670; ds_i = 1'b1; ksu_i = 2'b01; dm_i = 1'b1;
        @(negedge clk);
        check("R12 pc hold", pc_o, snap_pc);
        check("R12 epc hold", epc_o, m_epc);
        check("R12 code hold", {27'd0, code_o}, {27'd0, snap_code});
        check("R12 ksu follow", {30'd0, ksu_o}, 32'd1);
        check("R12 dm follow", {31'd0, dm_o}, 32'd1);

        // R11: unknown kind is ignored
        idle_inputs();
        snap_pc = pc_o; snap_code = code_o; snap_errpc = errpc_o; snap_depc = depc_o;
        kind_i = 5'd14; pc_i = 32'h0BAD_0000; ds_i = 1'b1;
        pulse();
        check("R11 unknown pc", pc_o, snap_pc);
        check("R11 unknown code", {27'd0, code_o}, {27'd0, snap_code});
        check("R11 unknown epc", epc_o, m_epc);
        check("R11 unknown bd", {31'd0, bd_o}, {31'd0, m_bd});
        check("R11 unknown errpc/depc", errpc_o | depc_o, snap_errpc | snap_depc);
        check("R11 unknown ksu passes", {30'd0, ksu_o}, 32'd2);

        // R9: NMI in a delay slot
        idle_inputs();
        kind_i = 5'd24; pc_i = 32'h0000_2000; ds_i = 1'b1;
        pulse();
        check("R9 nmi pc", pc_o, 32'hBFC0_0000);
        check("R9 nmi errpc", errpc_o, 32'h0000_1FFC);
        check("R9 nmi erl/bev/nmi/sr", {28'd0, erl_o, bev_o, nmi_o, sr_o}, 32'b1110);
        check("R9 nmi epc untouched", epc_o, m_epc);

        // R9: soft reset, not in slot
        idle_inputs();
        kind_i = 5'd25; pc_i = 32'h0000_3000;
        pulse();
        check("R9 srst errpc", errpc_o, 32'h0000_3000);
        check("R9 srst erl/bev/nmi/sr", {28'd0, erl_o, bev_o, nmi_o, sr_o}, 32'b1101);
        check("R11 srst ksu", {30'd0, ksu_o}, 32'd0);

        // R10: debug breakpoint in slot
        idle_inputs();
        snap_code = code_o;
        kind_i = 5'd28; pc_i = 32'h0000_4000; ds_i = 1'b1;
        pulse();
        check("R10 dbg pc", pc_o, 32'hBFC0_0480);
        check("R10 dbg depc", depc_o, 32'h0000_3FFC);
        check("R10 dbg dm", {31'd0, dm_o}, 32'd1);
        check("R10 dbg code held", {27'd0, code_o}, {27'd0, snap_code});

        // R10: interrupt while in debug mode becomes debug entry
        idle_inputs();
        snap_code = code_o;
        kind_i = 5'd0; pc_i = 32'h0000_5000; dm_i = 1'b1; iv_i = 1'b1;
        pulse();
        check("R10 dint pc", pc_o, 32'hBFC0_0480);
        check("R10 dint depc", depc_o, 32'h0000_5000);
        check("R10 dint epc untouched", epc_o, m_epc);
        check("R10 dint code held", {27'd0, code_o}, {27'd0, snap_code});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule